// File: doc/BRIEF.md
# UDP Broadcast Frame Streamer

This block turns a byte stream into a continuous train of broadcast UDP-over-IPv4 Ethernet frames. Each frame goes out on a 4-bit media-independent transmit interface as a nibble bus with a transmit enable. The block forms the whole frame itself: the preamble and start delimiter, the Ethernet header with a broadcast destination, the IPv4 header with a checksum computed in logic, the UDP header, a fixed-size payload and the trailing CRC-32 frame check sequence. It then holds the line idle for the inter-frame gap and starts the next frame at once.

Payload bytes arrive on a valid/ready handshake. The block asks for one byte every second nibble clock while the payload field is on the wire. When the source has no byte ready, the block sends zero in its place, so the frame timing never depends on the source. Static inputs supply the source MAC address, the source IPv4 address and the two UDP ports. A link-ready input lets frames start, and frames begin only on frame boundaries.

With the default payload of 1472 bytes, every frame is 1518 bytes long from destination address through frame check sequence.

Top module: `udp_bcast_streamer`

## Requirements
- R1: Every frame begins, in the cycle its transmit enable rises, with fifteen nibbles of 0x5 followed by one nibble of 0xD.
- R2: The header fields are as follows. Destination MAC FF:FF:FF:FF:FF:FF, then the source MAC, then type 0x0800. Next come IPv4 bytes 0x45, 0x00, total length 28+PAYLOAD_BYTES, identification 0, flags/fragment 0, TTL 0x80, protocol 0x11, then the source IP and destination IP 255.255.255.255. Last come the source port, destination port, UDP length 8+PAYLOAD_BYTES and a zero UDP checksum.
- R3: The IPv4 checksum field is the ones' complement of the end-around-carry sum of the ten 16-bit header words, with the checksum word taken as zero.
- R4: Each byte is sent low nibble first, and multi-byte fields are sent most significant byte first.
- R5: payReady is high only on the first nibble clock of each payload byte, and the byte accepted there is the byte sent in that position. This gives exactly PAYLOAD_BYTES ready cycles per frame.
- R6: When payValid is low in a ready cycle, the block sends a zero byte in that payload position and the frame keeps its length.
- R7: The last eight nibbles are the Ethernet CRC-32, computed over everything from the destination MAC through the payload: reflected polynomial 0xEDB88320, all-ones start, inverted result, least significant byte first, low nibble first.
- R8: txEn stays high for exactly 16 + 2*(46+PAYLOAD_BYTES) consecutive nibble clocks per frame.
- R9: With the link ready throughout, exactly GAP_NIBBLES idle clocks separate consecutive frames.
- R10: linkReady passes through two synchronising flops. txEn rises on the fourth clock edge after linkReady is first sampled high. No frame starts while the synchronised ready is low, and a frame in progress is always finished.
- R11: During reset txEn, txD and payReady are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkReady | input | 1 | Link may carry frames (asynchronous) |
| srcMac | input | 48 | Source MAC address |
| srcIp | input | 32 | Source IPv4 address |
| srcPort | input | 16 | UDP source port |
| dstPort | input | 16 | UDP destination port |
| payValid | input | 1 | Payload byte present |
| payData | input | 8 | Payload byte |
| payReady | output | 1 | Payload byte taken this clock |
| txD | output | 4 | Transmit nibble |
| txEn | output | 1 | Transmit enable |

## Verification
Every output nibble appears exactly one clock after the counter position that selects it. A payload byte accepted at an edge therefore shows its low nibble after that same edge and its high nibble one clock later. The frame check sequence trails the last payload nibble with no extra delay. The bench samples at falling edges and rebuilds each whole frame from its own byte model. That includes the checksum and a byte-wise reflected CRC, and it records which byte was offered in every ready cycle. Start latency is checked at exactly the third and fourth edges after linkReady rises. Idle spacing is counted nibble by nibble between frames.

// File: rtl/udp_strm_pkg.sv
package udp_strm_pkg;
  localparam int HDR_BYTES = 42;
  localparam int FCS_BYTES = 4;
  localparam int PRE_NIBS  = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SFD, PH_HDR, PH_PAY, PH_FCS
  } phase_e;

  typedef struct packed {
    phase_e     phase;
    logic       hiNib;
    logic [5:0] hdrIdx;
  } strobe_t;
endpackage

// File: rtl/udp_strm_ctrl.sv
module udp_strm_ctrl
  import udp_strm_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 1472,
  parameter int GAP_NIBBLES   = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    linkReady,
  output strobe_t stb,
  output logic    payReady
);
  localparam int HDR_END = PRE_NIBS + 2 * HDR_BYTES;
  localparam int PAY_END = HDR_END + 2 * PAYLOAD_BYTES;
  localparam int FCS_END = PAY_END + 2 * FCS_BYTES;
  localparam int LAST    = FCS_END + GAP_NIBBLES - 1;
  localparam int CW      = $clog2(LAST + 1);

  logic [1:0]    linkSync;
  logic          running;
  logic [CW-1:0] cnt;
  logic [CW-1:0] off;

  // position counter spans preamble, frame body and the idle gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkSync <= '0;
      running  <= 1'b0;
      cnt      <= '0;
    end else begin
      linkSync <= {linkSync[0], linkReady};
      if (!running) begin
        if (linkSync[1]) begin
          running <= 1'b1;
          cnt     <= '0;
        end
      end else if (cnt == CW'(LAST)) begin
        cnt     <= '0;
        running <= linkSync[1];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    off        = cnt - CW'(PRE_NIBS);
    stb.phase  = PH_IDLE;
    stb.hiNib  = cnt[0];
    stb.hdrIdx = 6'(off >> 1);
    if (running) begin
      if (cnt < CW'(PRE_NIBS - 1))      stb.phase = PH_PRE;
      else if (cnt == CW'(PRE_NIBS - 1)) stb.phase = PH_SFD;
      else if (cnt < CW'(HDR_END))       stb.phase = PH_HDR;
      else if (cnt < CW'(PAY_END))       stb.phase = PH_PAY;
      else if (cnt < CW'(FCS_END))       stb.phase = PH_FCS;
    end
    payReady = (stb.phase == PH_PAY) && !stb.hiNib;
  end
endmodule

// File: rtl/udp_strm_dp.sv
module udp_strm_dp
  import udp_strm_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 1472
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic        payValid,
  input  logic [7:0]  payData,
  input  logic [47:0] srcMac,
  input  logic [31:0] srcIp,
  input  logic [15:0] srcPort,
  input  logic [15:0] dstPort,
  output logic [3:0]  txD,
  output logic        txEn
);
  localparam logic [15:0] IP_LEN  = 16'(20 + 8 + PAYLOAD_BYTES);
  localparam logic [15:0] UDP_LEN = 16'(8 + PAYLOAD_BYTES);
  localparam logic [31:0] POLY    = 32'h04C1_1DB7;

  logic [31:0] sumW;
  logic [16:0] fold1;
  logic [15:0] ipCsum;
  logic [7:0]  hb;
  logic [7:0]  held;
  logic [7:0]  payByte;
  logic [31:0] crc;
  logic [3:0]  nib;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [3:0] n);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      if (n[i] == r[31]) r = {r[30:0], 1'b0};
      else               r = {r[30:0], 1'b0} ^ POLY;
    end
    return r;
  endfunction

  // header checksum: word sum, end-around carry, invert
  always_comb begin
    sumW   = 32'h4500 + 32'(IP_LEN) + 32'h8011 + {16'h0, srcIp[31:16]}
           + {16'h0, srcIp[15:0]} + 32'h0001_FFFE;
    fold1  = 17'(sumW[31:16]) + 17'(sumW[15:0]);
    ipCsum = ~(fold1[15:0] + 16'(fold1[16]));
  end

  always_comb begin
    hb = 8'h00;
    case (stb.hdrIdx) inside
      [6'd0:6'd5]:   hb = 8'hFF;
      [6'd6:6'd11]:  hb = srcMac[8 * (11 - int'(stb.hdrIdx)) +: 8];
      6'd12:         hb = 8'h08;
      6'd14:         hb = 8'h45;
      6'd16:         hb = IP_LEN[15:8];
      6'd17:         hb = IP_LEN[7:0];
      6'd22:         hb = 8'h80;
      6'd23:         hb = 8'h11;
      6'd24:         hb = ipCsum[15:8];
      6'd25:         hb = ipCsum[7:0];
      [6'd26:6'd29]: hb = srcIp[8 * (29 - int'(stb.hdrIdx)) +: 8];
      [6'd30:6'd33]: hb = 8'hFF;
      6'd34:         hb = srcPort[15:8];
      6'd35:         hb = srcPort[7:0];
      6'd36:         hb = dstPort[15:8];
      6'd37:         hb = dstPort[7:0];
      6'd38:         hb = UDP_LEN[15:8];
      6'd39:         hb = UDP_LEN[7:0];
      default:       hb = 8'h00;
    endcase
  end

  always_comb begin
    payByte = payValid ? payData : 8'h00;
    case (stb.phase)
      PH_PRE:  nib = 4'h5;
      PH_SFD:  nib = 4'hD;
      PH_HDR:  nib = stb.hiNib ? hb[7:4] : hb[3:0];
      PH_PAY:  nib = stb.hiNib ? held[7:4] : payByte[3:0];
      PH_FCS:  nib = ~{crc[28], crc[29], crc[30], crc[31]};
      default: nib = 4'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txD  <= 4'h0;
      txEn <= 1'b0;
      held <= 8'h00;
      crc  <= '1;
    end else begin
      txD  <= nib;
      txEn <= (stb.phase != PH_IDLE);
      if (stb.phase == PH_PAY && !stb.hiNib) held <= payByte;
      case (stb.phase)
        PH_HDR, PH_PAY: crc <= crcStep(crc, nib);
        PH_FCS:         crc <= {crc[27:0], 4'hF};
        default:        crc <= '1;
      endcase
    end
  end
endmodule

// File: rtl/udp_bcast_streamer.sv
module udp_bcast_streamer
  import udp_strm_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 1472,
  parameter int GAP_NIBBLES   = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkReady,
  input  logic [47:0] srcMac,
  input  logic [31:0] srcIp,
  input  logic [15:0] srcPort,
  input  logic [15:0] dstPort,
  input  logic        payValid,
  input  logic [7:0]  payData,
  output logic        payReady,
  output logic [3:0]  txD,
  output logic        txEn
);
  strobe_t stb;

  udp_strm_ctrl #(.PAYLOAD_BYTES(PAYLOAD_BYTES), .GAP_NIBBLES(GAP_NIBBLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .stb(stb), .payReady(payReady)
  );

  udp_strm_dp #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .payValid(payValid), .payData(payData),
    .srcMac(srcMac), .srcIp(srcIp), .srcPort(srcPort), .dstPort(dstPort),
    .txD(txD), .txEn(txEn)
  );
endmodule

// File: rtl/udp_strm_chk.sv
module udp_strm_chk #(
  parameter int PAYLOAD_BYTES = 1472,
  parameter int GAP_NIBBLES   = 24
) (
  input logic       clk,
  input logic       rstN,
  input logic       txEn,
  input logic [3:0] txD,
  input logic       payReady
);
  localparam int FRAME_N = 16 + 2 * (46 + PAYLOAD_BYTES);

  logic [15:0] runCnt;
  logic [15:0] idleCnt;
  logic        seenFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      idleCnt   <= '0;
      seenFrame <= 1'b0;
    end else begin
      if (txEn) begin
        runCnt    <= runCnt + 16'd1;
        idleCnt   <= '0;
        seenFrame <= 1'b1;
      end else begin
        if (idleCnt != 16'hFFFF) idleCnt <= idleCnt + 16'd1;
        if ($past(txEn) == 1'b0) runCnt <= '0;
      end
    end
  end

  p_preamble_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> txD == 4'h5);

  p_ready_drives_nibble_r5: assert property (@(posedge clk) disable iff (!rstN)
    payReady |=> txEn);

  p_ready_alternates_r5: assert property (@(posedge clk) disable iff (!rstN)
    payReady |=> !payReady);

  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEn) |-> runCnt == 16'(FRAME_N));

  p_gap_min_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txEn) && seenFrame) |-> idleCnt >= 16'(GAP_NIBBLES));
endmodule

bind udp_bcast_streamer udp_strm_chk #(
  .PAYLOAD_BYTES(PAYLOAD_BYTES), .GAP_NIBBLES(GAP_NIBBLES)
) u_chk (
  .clk(clk), .rstN(rstN), .txEn(txEn), .txD(txD), .payReady(payReady)
);

// File: tb/udp_bcast_streamer_tb.sv
module udp_bcast_streamer_tb;
  localparam int P       = 6;
  localparam int GAP     = 24;
  localparam int FRAME_N = 16 + 2 * (46 + P);

  localparam logic [47:0] MAC   = 48'h02_12_34_56_78_9A;
  localparam logic [31:0] IP    = 32'hC0A8_0A05;
  localparam logic [15:0] SPORT = 16'h1234;
  localparam logic [15:0] DPORT = 16'h4321;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       linkReady = 1'b0;
  logic       payValid = 1'b0;
  logic [7:0] payData = 8'h00;
  logic       payReady;
  logic [3:0] txD;
  logic       txEn;

  int checks = 0;
  int failures = 0;
  int frames = 0;
  int doneFrames = 0;
  int capLen = 0;
  int idleCnt = 0;
  int expIdx = 0;
  int readyCnt = 0;
  int curMode = 0;
  bit prevEn = 1'b0;
  logic [3:0] cap [0:511];
  logic [7:0] expPay [0:63];

  always #2.5 clk = ~clk;

  udp_bcast_streamer #(.PAYLOAD_BYTES(P), .GAP_NIBBLES(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .linkReady(linkReady), .srcMac(MAC), .srcIp(IP),
    .srcPort(SPORT), .dstPort(DPORT), .payValid(payValid), .payData(payData),
    .payReady(payReady), .txD(txD), .txEn(txEn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmpRange(input logic [3:0] en [0:511], input int a, input int b, input string tag);
    int bad = -1;
    for (int i = a; i < b; i++) if (bad < 0 && cap[i] !== en[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s nibble %0d", tag, bad), int'(cap[bad]), int'(en[bad]));
  endtask

  task automatic evalFrame();
    logic [7:0]  fb [0:255];
    logic [3:0]  en [0:511];
    logic [31:0] s;
    logic [31:0] c;
    logic [15:0] cs;
    int nb;
    nb = 42 + P;
    for (int i = 0; i < 256; i++) fb[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin
      fb[i]     = 8'hFF;
      fb[6 + i] = MAC[47 - 8 * i -: 8];
    end
    fb[12] = 8'h08; fb[14] = 8'h45;
    fb[16] = 8'((28 + P) >> 8); fb[17] = 8'(28 + P);
    fb[22] = 8'h80; fb[23] = 8'h11;
    for (int i = 0; i < 4; i++) begin
      fb[26 + i] = IP[31 - 8 * i -: 8];
      fb[30 + i] = 8'hFF;
    end
    fb[34] = SPORT[15:8]; fb[35] = SPORT[7:0];
    fb[36] = DPORT[15:8]; fb[37] = DPORT[7:0];
    fb[38] = 8'((8 + P) >> 8); fb[39] = 8'(8 + P);
    s = 0;
    for (int w = 0; w < 10; w++) s = s + {16'h0, fb[14 + 2 * w], fb[15 + 2 * w]};
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    cs = ~s[15:0];
    fb[24] = cs[15:8]; fb[25] = cs[7:0];
    for (int i = 0; i < P; i++) fb[42 + i] = expPay[i];
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < nb; i++) begin
      c = c ^ {24'h0, fb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) fb[nb + i] = c[8 * i +: 8];
    for (int i = 0; i < 15; i++) en[i] = 4'h5;
    en[15] = 4'hD;
    for (int i = 0; i < nb + 4; i++) begin
      en[16 + 2 * i]     = fb[i][3:0];
      en[16 + 2 * i + 1] = fb[i][7:4];
    end
    chk(capLen == FRAME_N, "R8 frame length", capLen, FRAME_N);
    cmpRange(en, 0, 16, "R1 preamble");
    cmpRange(en, 16, 64, "R2 header head");
    cmpRange(en, 68, 100, "R2 header tail");
    cmpRange(en, 64, 68, "R3 ip checksum");
    chk(cap[28] == MAC[43:40] && cap[29] == MAC[47:44], "R4 nibble order",
        int'({cap[29], cap[28]}), int'(MAC[47:40]));
    cmpRange(en, 100, 100 + 2 * P, curMode == 0 ? "R5 payload" : "R6 stalled payload");
    chk(readyCnt == P, "R5 ready count", readyCnt, P);
    cmpRange(en, 100 + 2 * P, 108 + 2 * P, "R7 fcs");
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (curMode == 0)      payValid = 1'b1;
      else if (curMode == 1) payValid = (expIdx % 2 == 0);
      else                   payValid = 1'b0;
      payData = 8'(8'h3C + expIdx * 7 + frames * 16);
      if (payReady) begin
        if (expIdx < 64) expPay[expIdx] = payValid ? payData : 8'h00;
        expIdx++;
        readyCnt++;
      end
      if (txEn) begin
        if (!prevEn) begin
          if (frames > 0) chk(idleCnt == GAP, "R9 inter-frame gap", idleCnt, GAP);
          frames++;
          curMode = (frames - 1) % 3;
          expIdx = 0; readyCnt = 0; capLen = 0; idleCnt = 0;
        end
        if (capLen < 512) cap[capLen] = txD;
        capLen++;
      end else begin
        if (prevEn) begin
          evalFrame();
          doneFrames++;
        end
        idleCnt++;
      end
      prevEn = txEn;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txEn == 1'b0 && txD == 4'h0 && payReady == 1'b0, "R11 reset outputs",
        int'({txEn, txD, payReady}), 0);
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    chk(frames == 0 && txEn == 1'b0, "R10 no frame while link down", frames, 0);
    linkReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(txEn == 1'b0, "R10 start not before fourth edge", int'(txEn), 0);
    @(posedge clk);
    @(negedge clk);
    chk(txEn == 1'b1 && txD == 4'h5, "R10 start on fourth edge", int'(txEn), 1);
    while (frames < 4) @(negedge clk);
    repeat (30) @(negedge clk);
    linkReady = 1'b0;
    while (doneFrames < 4) @(negedge clk);
    repeat (400) @(negedge clk);
    chk(frames == 4 && doneFrames == 4, "R10 finished frame then stop", frames, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", doneFrames, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule